// File: doc/BRIEF.md
# Auto-Restart Fault Timer

This block supervises regulation in an on/off switching controller. During an on-period it counts oscillator cycles for which the feedback has not been pulled high. If that run reaches a programmed limit, it forces switching off for an off-time. When the off-time ends it releases switching and emits a one-clock restart pulse, which starts a soft-start in the controller. The block keeps doing this until feedback is seen high again.

The off-time has two tiers. The first off-time after a healthy on-period uses a short count. Each further off-time, while the fault persists, uses a second, longer count, normally ten times the first. A strobe that sees feedback high during an on-period returns the block to the short tier. An external shutdown request from the enable controller starts an off-time at once, under the same tier rules. All durations are input counts measured in oscillator strobes. The block advances only on the strobe, apart from the immediate entry on a shutdown request.

Top module: `fault_restart_timer`

## Requirements
- R1: After reset, `sw_disable` and `restart_pulse` are 0, and the next off-time uses the short tier.
- R2: While switching is enabled, only `cyc_en` strobes that sample `fb_high` low advance the fault count. The clock edge of the `cfg_timeout`-th consecutive such strobe raises `sw_disable`. Without strobes, `sw_disable` does not change.
- R3: A strobe during an on-period that samples `fb_high` high clears the fault count, so a full `cfg_timeout` further low strobes are needed before the next off-time.
- R4: An off-time entered from the short tier lasts exactly `cfg_off_first` strobes. The strobe that enters the off-time is not counted, and the last counted strobe ends it.
- R5: Every off-time entered with no `fb_high` strobe since the previous off-time lasts exactly `cfg_off_next` strobes.
- R6: A strobe during an on-period that samples `fb_high` high returns the block to the short tier, so the next off-time lasts `cfg_off_first` strobes.
- R7: `restart_pulse` is high for exactly one clock cycle. It is high in the same cycle in which `sw_disable` first reads 0 after an off-time.
- R8: `shutdown_req`, sampled high at any clock edge while switching is enabled, sets `sw_disable` at that edge, with or without a strobe. The off-time length follows the rules of R4 and R5.
- R9: `shutdown_req` during an off-time has no effect: the off-time keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | One-clock strobe at the start of each oscillator cycle |
| fb_high | input | 1 | Feedback pulled high (regulation seen); sampled on strobes |
| shutdown_req | input | 1 | Immediate off-time request from the enable controller |
| cfg_timeout | input | CNT_W | Consecutive low-feedback strobes that trigger an off-time |
| cfg_off_first | input | CNT_W | Off-time length in strobes for the short tier (0 acts as 1) |
| cfg_off_next | input | CNT_W | Off-time length in strobes for the long tier (0 acts as 1) |
| sw_disable | output | 1 | High while switching is forced off |
| restart_pulse | output | 1 | One-clock pulse when an off-time ends |

## Verification
A wrong tier flag shows up as the wrong off-time length. It becomes visible when the following off-time ends, which is up to one long off-time later, so the bench measures each off-time in strobes over a run of repeated faults. A fault count that fails to clear or to advance moves the rising edge of `sw_disable` by at least one strobe within a single on-period. An off counter that is corrupted, or that counts clocks where it should count strobes, changes the measured off length at once. A badly registered exit shows as a `restart_pulse` that is missing, lasts too long, or does not line up with the fall of `sw_disable` in the same cycle.

// File: rtl/frt_pkg.sv
package frt_pkg;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_OFF = 1'b1
    } frt_state_e;

    typedef enum logic {
        TIER_SHORT = 1'b0,
        TIER_LONG  = 1'b1
    } frt_tier_e;

    typedef struct packed {
        frt_state_e state;
        frt_tier_e  tier;
        logic       restart;
    } frt_ctl_t;

endpackage

// File: rtl/frt_fault_window.sv
module frt_fault_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             fb_high,
    input  logic             armed,
    input  logic [CNT_W-1:0] limit,
    output logic             expire,
    output logic             fb_seen
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    always_comb begin
        cnt_d   = cnt_q;
        expire  = 1'b0;
        fb_seen = 1'b0;
        if (!armed) begin
            cnt_d = '0;
        end else if (cyc_en) begin
            if (fb_high) begin
                cnt_d   = '0;
                fb_seen = 1'b1;
            end else if (cnt_inc >= limit) begin
                cnt_d  = '0;
                expire = 1'b1;
            end else begin
                cnt_d = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cyc_en && fb_high) |=> (cnt_q == '0)); // R3

    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cyc_en && $past(armed)) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/frt_off_timer.sv
module frt_off_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        done  = 1'b0;
        if (load) begin
            cnt_d = (load_len == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : load_len;
        end else if (cyc_en && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
            done  = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_OFF_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !load) |=> $stable(cnt_q)); // R4

    AST_OFF_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0)); // R5

endmodule

// File: rtl/fault_restart_timer.sv
module fault_restart_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             fb_high,
    input  logic             shutdown_req,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic [CNT_W-1:0] cfg_off_first,
    input  logic [CNT_W-1:0] cfg_off_next,
    output logic             sw_disable,
    output logic             restart_pulse
);
    import frt_pkg::*;

    localparam frt_ctl_t CTL_RESET = '{state: ST_RUN, tier: TIER_SHORT, restart: 1'b0};

    frt_ctl_t         ctl_d, ctl_q;
    logic             armed;
    logic             expire;
    logic             fb_seen;
    logic             enter_off;
    logic             off_done;
    logic [CNT_W-1:0] off_len;

    assign armed   = (ctl_q.state == ST_RUN);
    assign off_len = (ctl_q.tier == TIER_SHORT) ? cfg_off_first : cfg_off_next;

    frt_fault_window #(.CNT_W(CNT_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_en  (cyc_en),
        .fb_high (fb_high),
        .armed   (armed),
        .limit   (cfg_timeout),
        .expire  (expire),
        .fb_seen (fb_seen)
    );

    frt_off_timer #(.CNT_W(CNT_W)) u_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .load     (enter_off),
        .load_len (off_len),
        .done     (off_done)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.restart = 1'b0;
        enter_off     = 1'b0;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (fb_seen) ctl_d.tier = TIER_SHORT;
                if (expire || shutdown_req) begin
                    enter_off   = 1'b1;
                    ctl_d.state = ST_OFF;
                    ctl_d.tier  = TIER_LONG;
                end
            end
            ST_OFF: begin
                if (off_done) begin
                    ctl_d.state   = ST_RUN;
                    ctl_d.restart = 1'b1;
                end
            end
            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign sw_disable    = (ctl_q.state == ST_OFF);
    assign restart_pulse = ctl_q.restart;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse); // R7

    AST_PULSE_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> (!sw_disable && $past(sw_disable))); // R7

    AST_SHUTDOWN_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_disable && shutdown_req) |=> sw_disable); // R8

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !shutdown_req) |=> $stable(sw_disable)); // R2

    AST_OFF_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_disable && !cyc_en) |=> sw_disable); // R9

endmodule

// File: tb/tb_fault_restart_timer.sv
module tb_fault_restart_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int STROBE_P   = 4;
    localparam int T_OUT      = 5;
    localparam int OFF_A      = 3;
    localparam int OFF_B      = 30;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cyc_en = 1'b0;
    logic             fb_high = 1'b0;
    logic             shutdown_req = 1'b0;
    logic [CNT_W-1:0] cfg_timeout = CNT_W'(T_OUT);
    logic [CNT_W-1:0] cfg_off_first = CNT_W'(OFF_A);
    logic [CNT_W-1:0] cfg_off_next = CNT_W'(OFF_B);
    logic             sw_disable;
    logic             restart_pulse;

    int checks = 0;
    int failures = 0;
    bit gen_on = 1'b0;
    int ph = 0;
    bit finished = 1'b0;

    int off_log [0:31];
    int on_log  [0:31];
    int off_n = 0, on_n = 0, off_run = 0, on_run = 0, pulse_bad = 0;
    bit dis_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_restart_timer #(.CNT_W(CNT_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_en        (cyc_en),
        .fb_high       (fb_high),
        .shutdown_req  (shutdown_req),
        .cfg_timeout   (cfg_timeout),
        .cfg_off_first (cfg_off_first),
        .cfg_off_next  (cfg_off_next),
        .sw_disable    (sw_disable),
        .restart_pulse (restart_pulse)
    );

    // strobe generator, driven away from the active edge
    always @(negedge clk) begin
        if (!gen_on) begin
            cyc_en <= 1'b0;
            ph     <= 0;
        end else begin
            cyc_en <= (ph == STROBE_P-1);
            ph     <= (ph == STROBE_P-1) ? 0 : ph + 1;
        end
    end

    // monitor: cyc_en read here still holds the value seen at the last posedge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc_en && dis_prev)  off_run++;
            if (cyc_en && !dis_prev) on_run++;
            if (dis_prev && !sw_disable) begin
                off_log[off_n % 32] = off_run;
                off_n++;
                off_run = 0;
                on_run  = 0;
                if (!restart_pulse) pulse_bad++;
            end
            if (!dis_prev && sw_disable) begin
                on_log[on_n % 32] = on_run;
                on_n++;
                on_run = 0;
            end
            if (restart_pulse && !(dis_prev && !sw_disable)) pulse_bad++;
            dis_prev = sw_disable;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_off_count(input int target);
        for (int i = 0; i < 20000 && off_n < target; i++) @(negedge clk);
    endtask

    task automatic wait_on_count(input int target);
        for (int i = 0; i < 20000 && on_n < target; i++) @(negedge clk);
    endtask

    task automatic fb_one_strobe();
        @(negedge clk) fb_high <= 1'b1;
        repeat (STROBE_P) @(negedge clk);
        fb_high <= 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sw_disable == 1'b0, "R1 sw_disable after reset", int'(sw_disable), 0);
        chk(restart_pulse == 1'b0, "R1 restart_pulse after reset", int'(restart_pulse), 0);
        repeat (60) @(negedge clk);
        chk(sw_disable == 1'b0, "R2 no strobes, no fault", int'(sw_disable), 0);
    endtask

    task automatic t_persistent();
        gen_on = 1'b1;
        wait_off_count(3);
        chk(on_log[0] == T_OUT, "R2 first on-time strobes", on_log[0], T_OUT);
        chk(off_log[0] == OFF_A, "R4 first off-time", off_log[0], OFF_A);
        chk(off_log[1] == OFF_B, "R5 second off-time", off_log[1], OFF_B);
        chk(off_log[2] == OFF_B, "R5 third off-time", off_log[2], OFF_B);
        chk(on_log[1] == T_OUT, "R2 on-time after restart", on_log[1], T_OUT);
        chk(pulse_bad == 0, "R7 restart pulse shape", pulse_bad, 0);
    endtask

    task automatic t_recover();
        int base_on;
        int base_off;
        base_on  = on_n;
        base_off = off_n;
        fb_one_strobe();
        wait_off_count(base_off + 2);
        chk(on_log[base_on % 32] > T_OUT, "R3 fb strobe extends on-time", on_log[base_on % 32], T_OUT + 1);
        chk(off_log[base_off % 32] == OFF_A, "R6 short tier after recovery", off_log[base_off % 32], OFF_A);
        chk(off_log[(base_off + 1) % 32] == OFF_B, "R5 long tier resumes", off_log[(base_off + 1) % 32], OFF_B);
        chk(pulse_bad == 0, "R7 restart pulse shape", pulse_bad, 0);
    endtask

    task automatic t_shutdown();
        int base_off;
        // regulate: fb held high, no faults
        @(negedge clk) fb_high <= 1'b1;
        repeat (3 * STROBE_P) @(negedge clk);
        chk(sw_disable == 1'b0, "R3 regulated, enabled", int'(sw_disable), 0);
        // request off between strobes
        while (cyc_en) @(negedge clk);
        base_off = off_n;
        shutdown_req <= 1'b1;
        @(negedge clk) shutdown_req <= 1'b0;
        chk(sw_disable == 1'b1, "R8 immediate off on request", int'(sw_disable), 1);
        repeat (STROBE_P) @(negedge clk);
        shutdown_req <= 1'b1;
        @(negedge clk) shutdown_req <= 1'b0;
        wait_off_count(base_off + 1);
        chk(off_log[base_off % 32] == OFF_A, "R8 R9 short off on request", off_log[base_off % 32], OFF_A);
        // request again with no fb strobe in between: long tier
        fb_high <= 1'b0;
        base_off = off_n;
        shutdown_req <= 1'b1;
        @(negedge clk);
        repeat (10 * STROBE_P) @(negedge clk);
        shutdown_req <= 1'b0;
        wait_off_count(base_off + 1);
        chk(off_log[base_off % 32] == OFF_B, "R8 R9 long off on repeat request", off_log[base_off % 32], OFF_B);
        chk(pulse_bad == 0, "R7 restart pulse shape", pulse_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_persistent();
        t_recover();
        t_shutdown();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule